// File: doc/BRIEF.md
# OTP OR-Merge Byte-Write Sequencer

This block merges a run of bytes into a one-time-programmable array without any software involvement. A request gives a start offset and a byte count. The bytes then arrive on a valid/ready stream. The sequencer acts as a master on the 32-bit register bus of the OTP controller and issues every register access itself.

The block first powers the array up and waits for the charge pump to settle. For each streamed byte it then does the following. A zero byte is consumed with no bus access at all. A non-zero byte causes a read of the stored byte. The sequencer ORs the two values, and it issues a program command only when the OR would change a bit. The run ends after the last byte or at the first error, whichever comes first. In both cases the array is powered down again. After that, a one-cycle done pulse is raised together with a status code.

Every wait on a controller flag is bounded by a cycle-count timeout. Because OTP bits can only go from 0 to 1, the OR-merge makes a repeated request harmless: it programs nothing the second time.

Top module: `otp_merge_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1 while `done_o`, `bus_req_o` and `byte_ready_o` are 0. A request is accepted only while `req_ready_o` is 1, which holds only when the block is idle. A request presented while a run is active has no effect.
- R2: Power-up comes before any byte is taken. On acceptance, the next bus access writes 0 to the power register (0x00, bit 0 = power-down). The block then reads the status register (0x04) until its bit 1 (pump active) reads 0.
- R3: A zero input byte is consumed with no command on the bus. `byte_ready_o` is never high while a bus access is pending.
- R4: A non-zero byte at offset A starts a read command. It writes A[15:8] to 0x08, then A[7:0] to 0x0C, then function 1 to 0x18, then 1 to the GO register 0x1C. The block then reads 0x1C until bit 0 is 0, reads 0x04 until bit 0 (busy) is 0, reads the result register 0x20, and finally reads the stored byte from 0x24.
- R5: If result bit 3 (read denied) is set after a read, the run stops with status 2.
- R6: The new value is stored OR input. A program is issued only when this differs from the stored byte. The program writes 0x08, then 0x0C, then mode 1 to 0x10, then the new value to 0x14, then function 2 to 0x18, then GO. It then waits on GO and busy as in R4 and reads 0x20.
- R7: After a program, result bit 2 (write denied) gives status 3 and takes priority over bit 0 (fail), which gives status 4. Either one stops the run.
- R8: A flag that is still set when TIMEOUT_CYC cycles have passed in its poll ends the run with status 1.
- R9: Every run ends by writing 1 to the power register. `done_o` is high for exactly the one cycle after that write is acknowledged, and `status_o` is valid with it.
- R10: A bus access completes on a cycle with `bus_req_o` and `bus_ack_i` both high. Until then, request, address, direction and write data stay stable.
- R11: A run that processes all its bytes reports status 0. This includes a count of zero, which still powers up and down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Idle, request can be taken |
| req_offset_i | input | OTP_AW | First byte offset |
| req_count_i | input | OTP_AW+1 | Number of bytes |
| byte_valid_i | input | 1 | Input byte valid |
| byte_ready_o | output | 1 | Input byte taken this cycle |
| byte_data_i | input | 8 | Input byte |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | 0 ok, 1 timeout, 2 read denied, 3 write denied, 4 program fail |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | 8 | Register byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access completes |
| bus_rdata_i | input | 32 | Read data, valid with ack |

## Verification
The hardest situations to reach from the ports are the error exits in the middle of a run. Examples are a denied read on the second non-zero byte, or a write-denied flag raised together with a fail flag on the same program. A deny or fail flag is an attribute of one address in the behavioural controller model, so a stream can be arranged to reach the faulty byte only after earlier bytes were merged. The model can also hold the GO flag or the pump flag stuck, which drives both timeout paths. In every case the bench checks how many bytes were consumed, how many commands and programs were issued, and that the array ended powered down.

// File: rtl/otp_merge_pkg.sv
package otp_merge_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] REG_PWR   = 8'h00;
  localparam logic [REG_AW-1:0] REG_STAT  = 8'h04;
  localparam logic [REG_AW-1:0] REG_AHI   = 8'h08;
  localparam logic [REG_AW-1:0] REG_ALO   = 8'h0C;
  localparam logic [REG_AW-1:0] REG_MODE  = 8'h10;
  localparam logic [REG_AW-1:0] REG_PDATA = 8'h14;
  localparam logic [REG_AW-1:0] REG_FUNC  = 8'h18;
  localparam logic [REG_AW-1:0] REG_GO    = 8'h1C;
  localparam logic [REG_AW-1:0] REG_RES   = 8'h20;
  localparam logic [REG_AW-1:0] REG_RDATA = 8'h24;

  localparam int STAT_BUSY = 0;
  localparam int STAT_PUMP = 1;
  localparam int RES_FAIL  = 0;
  localparam int RES_WDENY = 2;
  localparam int RES_RDENY = 3;

  localparam logic [7:0] FUNC_RD  = 8'h01;
  localparam logic [7:0] FUNC_PGM = 8'h02;

  typedef enum logic [2:0] {
    RC_OK        = 3'd0,
    RC_TIMEOUT   = 3'd1,
    RC_RD_DENY   = 3'd2,
    RC_WR_DENY   = 3'd3,
    RC_PROG_FAIL = 3'd4
  } rc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR_UP, S_POLL_PUMP, S_NEXT, S_FETCH, S_CMD,
    S_POLL_GO, S_POLL_BUSY, S_RESULT, S_RDATA, S_PWR_DN, S_DONE
  } seq_e;
endpackage

// File: rtl/otp_poll_timer.sv
module otp_poll_timer #(
  parameter int LIMIT = 64,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));

  AST_TIMER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !clr_i |=> expired_o); // R8
endmodule

// File: rtl/otp_cmd_rom.sv
module otp_cmd_rom
  import otp_merge_pkg::*;
#(
  parameter int OTP_AW = 13
) (
  input  logic              prog_i,
  input  logic [2:0]        step_i,
  input  logic [OTP_AW-1:0] offset_i,
  input  logic [7:0]        data_i,
  output logic [REG_AW-1:0] reg_o,
  output logic [31:0]       wdata_o,
  output logic              last_o
);
  logic [15:0] off16;
  assign off16 = 16'(offset_i);

  always_comb begin
    reg_o   = REG_GO;
    wdata_o = 32'd1;
    last_o  = 1'b0;
    if (!prog_i) begin
      case (step_i)
        3'd0:    begin reg_o = REG_AHI;  wdata_o = {24'd0, off16[15:8]}; end
        3'd1:    begin reg_o = REG_ALO;  wdata_o = {24'd0, off16[7:0]};  end
        3'd2:    begin reg_o = REG_FUNC; wdata_o = {24'd0, FUNC_RD};     end
        default: last_o = 1'b1;
      endcase
    end else begin
      case (step_i)
        3'd0:    begin reg_o = REG_AHI;   wdata_o = {24'd0, off16[15:8]}; end
        3'd1:    begin reg_o = REG_ALO;   wdata_o = {24'd0, off16[7:0]};  end
        3'd2:    begin reg_o = REG_MODE;  wdata_o = 32'd1;                end
        3'd3:    begin reg_o = REG_PDATA; wdata_o = {24'd0, data_i};      end
        3'd4:    begin reg_o = REG_FUNC;  wdata_o = {24'd0, FUNC_PGM};    end
        default: last_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/otp_merge_seq.sv
module otp_merge_seq
  import otp_merge_pkg::*;
#(
  parameter int OTP_AW      = 13,
  parameter int TIMEOUT_CYC = 64,
  localparam int CNT_W      = OTP_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OTP_AW-1:0] req_offset_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [7:0]        byte_data_i,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [REG_AW-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i
);
  seq_e              state_q;
  logic [2:0]        step_q;
  logic [OTP_AW-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [7:0]        in_q, new_q;
  logic              prog_q;
  rc_e               rc_q;

  logic              xfer, flag, in_poll, tmr_clr, expired;
  logic [REG_AW-1:0] rom_reg;
  logic [31:0]       rom_wdata;
  logic              rom_last;
  logic [7:0]        rd_byte;
  logic              unused_rdata;

  assign xfer         = bus_req_o & bus_ack_i;
  assign rd_byte      = bus_rdata_i[7:0];
  assign unused_rdata = ^bus_rdata_i[31:8];

  otp_cmd_rom #(.OTP_AW(OTP_AW)) u_rom (
    .prog_i  (prog_q),
    .step_i  (step_q),
    .offset_i(addr_q),
    .data_i  (new_q),
    .reg_o   (rom_reg),
    .wdata_o (rom_wdata),
    .last_o  (rom_last)
  );

  always_comb begin
    in_poll = 1'b1;
    flag    = 1'b0;
    case (state_q)
      S_POLL_PUMP: flag = bus_rdata_i[STAT_PUMP];
      S_POLL_GO:   flag = bus_rdata_i[0];
      S_POLL_BUSY: flag = bus_rdata_i[STAT_BUSY];
      default:     in_poll = 1'b0;
    endcase
  end

  assign tmr_clr = !in_poll | (xfer & !flag);

  otp_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .expired_o(expired)
  );

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b0;
    bus_addr_o  = REG_STAT;
    bus_wdata_o = 32'd0;
    case (state_q)
      S_PWR_UP:    begin bus_we_o = 1'b1; bus_addr_o = REG_PWR; end
      S_POLL_PUMP: bus_addr_o = REG_STAT;
      S_CMD:       begin bus_we_o = 1'b1; bus_addr_o = rom_reg; bus_wdata_o = rom_wdata; end
      S_POLL_GO:   bus_addr_o = REG_GO;
      S_POLL_BUSY: bus_addr_o = REG_STAT;
      S_RESULT:    bus_addr_o = REG_RES;
      S_RDATA:     bus_addr_o = REG_RDATA;
      S_PWR_DN:    begin bus_we_o = 1'b1; bus_addr_o = REG_PWR; bus_wdata_o = 32'd1; end
      default:     bus_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      in_q    <= '0;
      new_q   <= '0;
      prog_q  <= 1'b0;
      rc_q    <= RC_OK;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          addr_q  <= req_offset_i;
          rem_q   <= req_count_i;
          rc_q    <= RC_OK;
          state_q <= S_PWR_UP;
        end
        S_PWR_UP: if (xfer) state_q <= S_POLL_PUMP;
        S_POLL_PUMP: if (xfer) begin
          if (!flag) state_q <= S_NEXT;
          else if (expired) begin rc_q <= RC_TIMEOUT; state_q <= S_PWR_DN; end
        end
        S_NEXT: state_q <= (rem_q == '0) ? S_PWR_DN : S_FETCH;
        S_FETCH: if (byte_valid_i) begin
          in_q <= byte_data_i;
          if (byte_data_i == 8'd0) begin
            addr_q  <= addr_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            state_q <= S_NEXT;
          end else begin
            prog_q  <= 1'b0;
            step_q  <= '0;
            state_q <= S_CMD;
          end
        end
        S_CMD: if (xfer) begin
          if (rom_last) state_q <= S_POLL_GO;
          else          step_q  <= step_q + 1'b1;
        end
        S_POLL_GO: if (xfer) begin
          if (!flag) state_q <= S_POLL_BUSY;
          else if (expired) begin rc_q <= RC_TIMEOUT; state_q <= S_PWR_DN; end
        end
        S_POLL_BUSY: if (xfer) begin
          if (!flag) state_q <= S_RESULT;
          else if (expired) begin rc_q <= RC_TIMEOUT; state_q <= S_PWR_DN; end
        end
        S_RESULT: if (xfer) begin
          if (!prog_q) begin
            if (bus_rdata_i[RES_RDENY]) begin rc_q <= RC_RD_DENY; state_q <= S_PWR_DN; end
            else state_q <= S_RDATA;
          end else if (bus_rdata_i[RES_WDENY]) begin
            rc_q <= RC_WR_DENY; state_q <= S_PWR_DN;
          end else if (bus_rdata_i[RES_FAIL]) begin
            rc_q <= RC_PROG_FAIL; state_q <= S_PWR_DN;
          end else begin
            addr_q  <= addr_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            state_q <= S_NEXT;
          end
        end
        S_RDATA: if (xfer) begin
          new_q <= rd_byte | in_q;
          if ((rd_byte | in_q) == rd_byte) begin
            addr_q  <= addr_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            state_q <= S_NEXT;
          end else begin
            prog_q  <= 1'b1;
            step_q  <= '0;
            state_q <= S_CMD;
          end
        end
        S_PWR_DN: if (xfer) state_q <= S_DONE;
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == S_IDLE);
  assign byte_ready_o = (state_q == S_FETCH);
  assign done_o       = (state_q == S_DONE);
  assign status_o     = rc_q;

  AST_START_POWER_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> bus_req_o && bus_we_o && bus_addr_o == REG_PWR && !bus_wdata_o[0]); // R2
  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)); // R10
  AST_NO_BUS_ON_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !bus_req_o); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_req_o && bus_ack_i && bus_we_o && bus_addr_o == REG_PWR && bus_wdata_o[0])); // R9
  AST_STATUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && !$rose(bus_req_o) && !bus_req_o && !byte_ready_o |-> $stable(status_o)); // R9
endmodule

// File: tb/otp_merge_seq_tb_top.sv
`timescale 1ns/1ps
module otp_merge_seq_tb_top;
  import otp_merge_pkg::*;

  localparam int OTP_AW    = 13;
  localparam int CNT_W     = OTP_AW + 1;
  localparam int PUMP_LAT  = 5;
  localparam int GO_LAT    = 3;
  localparam int BUSY_LAT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [OTP_AW-1:0] req_offset = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              byte_valid = 1'b0;
  logic              byte_ready;
  logic [7:0]        byte_data = '0;
  logic              done;
  logic [2:0]        status;
  logic              bus_req, bus_we;
  logic [REG_AW-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_ack = 1'b0;
  logic [31:0]       bus_rdata = '0;

  otp_merge_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_offset_i(req_offset), .req_count_i(req_count),
    .byte_valid_i(byte_valid), .byte_ready_o(byte_ready), .byte_data_i(byte_data),
    .done_o(done), .status_o(status),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- controller model ----------------
  logic [7:0] otp_mem [int];
  logic [7:0] exp_mem [int];
  bit rd_deny [int];
  bit wr_deny [int];
  bit fail_at [int];
  bit stuck_go = 0, stuck_pump = 0;
  logic [7:0] m_ahi, m_alo, m_mode, m_pdata, m_func, m_rdata;
  logic [31:0] m_res;
  logic m_pwrdn;
  int pump_cnt, go_cnt, busy_cnt;
  int n_cmd = 0, n_prog = 0, order_err = 0, early_err = 0, down_access = 0;
  logic [7:0] hist [0:5];

  function automatic logic [7:0] rdm(input int a);
    return otp_mem.exists(a) ? otp_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rde(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction

  task automatic do_go();
    int a;
    a = {m_ahi, m_alo};
    n_cmd++;
    go_cnt = GO_LAT;
    busy_cnt = BUSY_LAT;
    m_res = '0;
    if (m_func == FUNC_RD) begin
      if (!(hist[2] == REG_AHI && hist[3] == REG_ALO && hist[4] == REG_FUNC)) order_err++;
      if (rd_deny.exists(a)) m_res[RES_RDENY] = 1'b1;
      else m_rdata = rdm(a);
    end else if (m_func == FUNC_PGM) begin
      n_prog++;
      if (!(hist[0] == REG_AHI && hist[1] == REG_ALO && hist[2] == REG_MODE &&
            hist[3] == REG_PDATA && hist[4] == REG_FUNC && m_mode == 8'd1)) order_err++;
      if (wr_deny.exists(a)) m_res[RES_WDENY] = 1'b1;
      if (fail_at.exists(a)) m_res[RES_FAIL] = 1'b1;
      if (m_res == 0) otp_mem[a] = rdm(a) | m_pdata;
    end else order_err++;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      bus_rdata <= '0;
      m_pwrdn = 1'b1;
      pump_cnt = 0; go_cnt = 0; busy_cnt = 0;
      m_ahi = 0; m_alo = 0; m_mode = 0; m_pdata = 0; m_func = 0; m_rdata = 0; m_res = 0;
      for (int k = 0; k < 6; k++) hist[k] = 8'hFF;
    end else begin
      if (pump_cnt > 0 && !stuck_pump) pump_cnt--;
      if (go_cnt > 0) begin
        if (!stuck_go) go_cnt--;
      end else if (busy_cnt > 0) busy_cnt--;
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (m_pwrdn && !(bus_we && bus_addr == REG_PWR)) down_access++;
        if (bus_we) begin
          for (int k = 0; k < 5; k++) hist[k] = hist[k+1];
          hist[5] = bus_addr;
          case (bus_addr)
            REG_PWR: begin
              if (m_pwrdn && !bus_wdata[0]) pump_cnt = PUMP_LAT;
              m_pwrdn = bus_wdata[0];
            end
            REG_AHI:   m_ahi   = bus_wdata[7:0];
            REG_ALO:   m_alo   = bus_wdata[7:0];
            REG_MODE:  m_mode  = bus_wdata[7:0];
            REG_PDATA: m_pdata = bus_wdata[7:0];
            REG_FUNC:  m_func  = bus_wdata[7:0];
            REG_GO:    if (bus_wdata[0]) do_go();
            default:   order_err++;
          endcase
        end else begin
          case (bus_addr)
            REG_STAT:  bus_rdata <= {30'd0, pump_cnt > 0, busy_cnt > 0 || go_cnt > 0};
            REG_GO:    bus_rdata <= {31'd0, go_cnt > 0};
            REG_RES: begin
              if (go_cnt > 0 || busy_cnt > 0) early_err++;
              bus_rdata <= m_res;
            end
            REG_RDATA: bus_rdata <= {24'd0, m_rdata};
            default:   bus_rdata <= '0;
          endcase
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string nm; int rc; int cmds; int progs; int taken; int off; int n;
  } exp_t;
  exp_t exp_q[$];
  logic [7:0] stim_q[$];
  bit done_seen = 0;
  int taken = 0;

  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      int mism;
      done_seen = 1;
      if (exp_q.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk({"R5/R7/R8/R11 status ", e.nm}, int'(status), e.rc);
        chk({"R3/R4 command count ", e.nm}, n_cmd, e.cmds);
        chk({"R6 program count ", e.nm}, n_prog, e.progs);
        chk({"R5 bytes consumed ", e.nm}, taken, e.taken);
        mism = 0;
        for (int i = 0; i < e.n; i++)
          if (rdm(e.off + i) != rde(e.off + i)) mism++;
        chk({"R6 array contents ", e.nm}, mism, 0);
        chk({"R9 powered down ", e.nm}, int'(m_pwrdn), 1);
        chk({"R2 access while down ", e.nm}, down_access, 0);
        chk({"R4/R6 command order ", e.nm}, order_err, 0);
        chk({"R4 result before idle ", e.nm}, early_err, 0);
      end
    end
  end

  task automatic set_mem(input int a, input logic [7:0] v);
    otp_mem[a] = v;
    exp_mem[a] = v;
  endtask

  task automatic run_case(input string nm, input int off, input bit sp, input bit sg,
                          input bit poke_req);
    exp_t e;
    int idx;
    e.nm = nm; e.off = off; e.n = stim_q.size();
    e.rc = RC_OK; e.cmds = 0; e.progs = 0; e.taken = 0;
    if (sp) e.rc = RC_TIMEOUT;
    else begin
      for (int i = 0; i < stim_q.size(); i++) begin
        int a;
        logic [7:0] o, nw;
        a = off + i;
        e.taken++;
        if (stim_q[i] == 8'd0) continue;
        e.cmds++;
        if (sg) begin e.rc = RC_TIMEOUT; break; end
        if (rd_deny.exists(a)) begin e.rc = RC_RD_DENY; break; end
        o = rde(a);
        nw = o | stim_q[i];
        if (nw == o) continue;
        e.cmds++; e.progs++;
        if (wr_deny.exists(a)) begin e.rc = RC_WR_DENY; break; end
        if (fail_at.exists(a)) begin e.rc = RC_PROG_FAIL; break; end
        exp_mem[a] = nw;
      end
    end
    exp_q.push_back(e);
    stuck_pump = sp; stuck_go = sg;
    n_cmd = 0; n_prog = 0; done_seen = 0; taken = 0;
    @(negedge clk);
    req_offset = OTP_AW'(off);
    req_count = CNT_W'(stim_q.size());
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0;
    while (!done_seen) begin
      if (poke_req && idx == 1) begin
        chk("R1 not ready while busy", int'(req_ready), 0);
        req_offset = '0;
        req_valid = 1'b1;
      end else req_valid = 1'b0;
      byte_valid = (idx < stim_q.size());
      byte_data = byte_valid ? stim_q[idx] : 8'h00;
      if (byte_valid && byte_ready) idx++;
      taken = idx;
      @(negedge clk);
    end
    req_valid = 1'b0;
    byte_valid = 1'b0;
    stuck_pump = 0; stuck_go = 0;
    repeat (12) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset bus idle", int'(bus_req), 0);
    chk("R3 reset byte ready", int'(byte_ready), 0);

    // R6: merge with changed, unchanged and skipped bytes; R1: request poked mid-run
    set_mem(256, 8'hF0); set_mem(258, 8'hF0); set_mem(259, 8'h01);
    stim_q = '{8'h0F, 8'h00, 8'hF0, 8'h11};
    run_case("merge", 256, 0, 0, 1);

    // R3: all zero bytes, no commands
    stim_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_case("zeros", 512, 0, 0, 0);

    // R11: zero count
    stim_q = {};
    run_case("empty", 100, 0, 0, 0);

    // R6: repeat of merge programs nothing
    stim_q = '{8'h0F, 8'h00, 8'hF0, 8'h11};
    run_case("repeat", 256, 0, 0, 0);

    // R4: high offset split
    stim_q = '{8'h80, 8'h00, 8'h05};
    run_case("high offset", 13'h1ABC, 0, 0, 0);

    // R5: read denied on second non-zero byte
    rd_deny[1026] = 1;
    stim_q = '{8'h03, 8'h00, 8'h44, 8'h55};
    run_case("read deny", 1024, 0, 0, 0);

    // R7: write deny wins over fail
    wr_deny[2049] = 1; fail_at[2049] = 1;
    stim_q = '{8'h21, 8'h42, 8'h10};
    run_case("write deny priority", 2048, 0, 0, 0);

    // R7: program fail
    fail_at[3000] = 1;
    stim_q = '{8'h09, 8'h01};
    run_case("prog fail", 3000, 0, 0, 0);

    // R8: GO stuck
    stim_q = '{8'h00, 8'h07, 8'h01};
    run_case("go timeout", 4000, 0, 1, 0);

    // R8: pump stuck
    stim_q = '{8'h07};
    run_case("pump timeout", 4100, 1, 0, 0);

    // R11: clean run after errors
    stim_q = '{8'h01, 8'h02};
    run_case("recover", 4200, 0, 0, 0);

    chk("R9 all runs completed", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule